// File: doc/BRIEF.md
# Framed Full-Duplex Serial Slave Port

This block is the serial side of a converter-style device. An external master supplies a serial clock and a frame-sync strobe. In each frame the port shifts out a 16-bit word taken from a parallel input and, over the same frame, collects 16 bits from the data input. Bits travel most significant first. When the last bit has been collected, the received word appears on a parallel output together with a one-cycle strobe.

The serial clock and the sync line are sampled by the block's own system clock. Their edges are found by comparing each sample with the one before, so the master's serial clock must run well below the system clock. The serial output comes with a separate enable that drives the pad's three-state buffer.

A mode input picks one of two framing styles. In level framing, the sync line qualifies the whole frame: a frame ends when sync is released, and a sync held low cuts the clock stream into consecutive 16-bit frames. In edge framing, a falling sync edge starts a frame that always runs for 16 sampling edges, whatever sync does after that. A polarity input picks which serial-clock edge samples the data input and which edge advances the data output.

Top module: `sfp_port`

## Requirements
- R1: After a frame starts, `dout` presents bit 15 of the latched transmit word. Each shift edge that follows a sampling edge moves to the next lower bit, so bit 15-k is valid before sampling edge k (k counted from 0).
- R2: The bits sampled from `din` are assembled most significant first, so the first sampled bit lands in bit 15. `rx_word` takes the assembled word, and `rx_valid` is high for exactly one system-clock cycle, in the cycle after the 16th sampling edge.
- R3: With `pol`=0, rising `sclk` edges sample and falling edges shift. With `pol`=1 the two roles swap.
- R4: In level framing (`edge_mode`=0), `dout_oe` rises in the cycle after `sync_n` is seen low. It falls in the cycle after `sync_n` is seen high.
- R5: In level framing with `sync_n` held low, every group of 16 sampling edges forms its own frame. `tx_word` is latched again at each group boundary, `rx_valid` pulses once per group, and `dout_oe` stays high.
- R6: In level framing, raising `sync_n` before the 16th sampling edge abandons the frame without a `rx_valid` pulse. `sclk` edges that arrive while `sync_n` is high are ignored.
- R7: In edge framing (`edge_mode`=1), a falling `sync_n` starts a frame of exactly 16 sampling edges, even if `sync_n` returns high after the first bit. `dout_oe` is high for that frame and falls in the cycle after the 16th sampling edge.
- R8: In edge framing, sampling edges after the 16th have no effect until the next falling `sync_n`: no `rx_valid` pulse and `dout_oe` stays low.
- R9: In either mode, a falling `sync_n` during a frame restarts the bit count from zero with a freshly latched transmit word.
- R10: `tx_word` is latched when a frame starts. Changing it during the frame leaves the bits on `dout` unchanged.
- R11: In edge framing, when a falling `sync_n` arrives in the same cycle as the 16th sampling edge, the finished word is still delivered with `rx_valid`, and a new frame starts in that same cycle.
- R12: While `rst_n` is low, `dout_oe`, `dout`, `rx_valid` and `rx_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| sync_n | input | 1 | Frame-sync strobe, active low |
| din | input | 1 | Serial data from the master |
| pol | input | 1 | Clock-edge polarity select (0: sample on rising edge) |
| edge_mode | input | 1 | Framing select (0: level framing, 1: edge framing) |
| tx_word | input | 16 | Word to send in the next frame |
| dout | output | 1 | Serial data to the master; 0 while not enabled |
| dout_oe | output | 1 | Three-state enable for the `dout` pad |
| rx_word | output | 16 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_word` |

## Verification
The sharpest coincidence is a frame ending and a frame beginning in the same clock cycle. In edge framing, the bench drives the 16th sampling edge of `sclk` and a new falling `sync_n` on the same clock edge. It then requires the completed word with its strobe, a live output enable, and bit 15 of the new transmit word, followed by a full clean second frame. Level framing with `sync_n` held low gives the same overlap in a milder form: the group boundary both delivers a word and reloads the transmit word. The bench judges it by chaining two frames and checking both received words and the second frame's output bits.

// File: rtl/sfp_pkg.sv
// Shared types for the framed serial port.
// Assumes: serial-clock edges are detected in the system-clock domain.
package sfp_pkg;

    // Per-cycle serial events after polarity selection.
    typedef struct packed {
        logic samp;       // edge on which din is captured
        logic shft;       // edge on which dout advances
        logic sync_fall;  // frame-sync went from high to low
    } sfp_evt_t;

endpackage

// File: rtl/sfp_edge_det.sv
// Detects serial-clock and sync edges and maps clock edges to the
// sample/shift roles according to the polarity select.
// Assumes: sclk and sync_n are already synchronous to clk.
module sfp_edge_det
    import sfp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sclk,
    input  logic     sync_n,
    input  logic     pol,
    output sfp_evt_t evt
);

    logic sclk_q;
    logic sync_q;
    logic sclk_rise;
    logic sclk_fall;

    // Remember previous samples of sclk and sync_n.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sync_q <= 1'b1;
        end else begin
            sclk_q <= sclk;
            sync_q <= sync_n;
        end
    end

    // Edge decode and polarity role swap.
    always_comb begin
        sclk_rise     = sclk & ~sclk_q;
        sclk_fall     = ~sclk & sclk_q;
        evt.samp      = pol ? sclk_fall : sclk_rise;
        evt.shft      = pol ? sclk_rise : sclk_fall;
        evt.sync_fall = sync_q & ~sync_n;
    end

endmodule

// File: rtl/sfp_frame_ctl.sv
// Frame state: tracks whether a frame is open, counts sampling edges,
// and points at the transmit bit currently presented.
// Assumes: at most one sampling or shift edge per clk cycle.
module sfp_frame_ctl
    import sfp_pkg::*;
#(
    parameter int W  = 16,
    localparam int CW = $clog2(W + 1),
    localparam int IW = $clog2(W)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_mode,
    input  logic          sync_n,
    input  sfp_evt_t      evt,
    output logic          in_frame,
    output logic          take,
    output logic          last,
    output logic          load,
    output logic [IW-1:0] out_idx
);

    logic [CW-1:0] cnt;
    logic          alive;
    logic          lvl_drop;

    // Qualify events with the current framing state.
    always_comb begin
        alive    = in_frame & (edge_mode | ~sync_n);
        take     = alive & evt.samp & (cnt < CW'(W));
        last     = take & (cnt == CW'(W - 1));
        lvl_drop = ~edge_mode & sync_n;
        load     = evt.sync_fall | (last & ~edge_mode);
    end

    // Frame-open flag: set by sync fall, cleared by release or count end.
    always_ff @(posedge clk) begin
        if (!rst_n)                  in_frame <= 1'b0;
        else if (evt.sync_fall)      in_frame <= 1'b1;
        else if (lvl_drop)           in_frame <= 1'b0;
        else if (edge_mode && last)  in_frame <= 1'b0;
    end

    // Sampling-edge counter, restarted at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= '0;
        else if (lvl_drop)  cnt <= '0;
        else if (take)      cnt <= cnt + CW'(1);
    end

    // Output bit pointer: advances on a shift edge once its bit was sampled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_idx <= '0;
        else if (load || lvl_drop)
            out_idx <= '0;
        else if (alive && evt.shft && (CW'(out_idx) < cnt) && (out_idx < IW'(W - 1)))
            out_idx <= out_idx + IW'(1);
    end

endmodule

// File: rtl/sfp_tx_path.sv
// Transmit side: latches the parallel word at frame start and drives
// the selected bit with its output enable.
// Assumes: load and out_idx come from sfp_frame_ctl.
module sfp_tx_path #(
    parameter int W  = 16,
    localparam int IW = $clog2(W)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  tx_word,
    input  logic          in_frame,
    input  logic [IW-1:0] out_idx,
    output logic          dout,
    output logic          dout_oe
);

    logic [W-1:0] tx_hold;

    // Capture the transmit word at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    tx_hold <= '0;
        else if (load) tx_hold <= tx_word;
    end

    // Present the pointed bit, MSB first, gated by the enable.
    always_comb begin
        dout_oe = in_frame;
        dout    = in_frame & tx_hold[IW'(W - 1) - out_idx];
    end

endmodule

// File: rtl/sfp_rx_path.sv
// Receive side: shifts in sampled bits and publishes the word with a
// one-cycle strobe when the frame's last bit arrives.
// Assumes: take/last are single-cycle pulses from sfp_frame_ctl.
module sfp_rx_path #(
    parameter int W = 16
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         last,
    input  logic         din,
    output logic [W-1:0] rx_word,
    output logic         rx_valid
);

    logic [W-1:0] rx_shift;
    logic [W-1:0] rx_next;

    // Next shift contents with the newly sampled bit appended.
    always_comb rx_next = {rx_shift[W-2:0], din};

    // Shift register for incoming bits.
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_shift <= '0;
        else if (take) rx_shift <= rx_next;
    end

    // Holding register and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= last;
            if (last) rx_word <= rx_next;
        end
    end

endmodule

// File: rtl/sfp_port.sv
// Top of the framed serial slave port: edge detection, frame control,
// transmit and receive paths.
// Assumes: sclk/sync_n are synchronous to clk and slower than clk/2.
module sfp_port
    import sfp_pkg::*;
#(
    parameter int W  = 16,
    localparam int IW = $clog2(W)
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         sync_n,
    input  logic         din,
    input  logic         pol,
    input  logic         edge_mode,
    input  logic [W-1:0] tx_word,
    output logic         dout,
    output logic         dout_oe,
    output logic [W-1:0] rx_word,
    output logic         rx_valid
);

    sfp_evt_t      evt;
    logic          in_frame;
    logic          take;
    logic          last;
    logic          load;
    logic [IW-1:0] out_idx;

    sfp_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk   (sclk),
        .sync_n (sync_n),
        .pol    (pol),
        .evt    (evt)
    );

    sfp_frame_ctl #(.W(W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_mode (edge_mode),
        .sync_n    (sync_n),
        .evt       (evt),
        .in_frame  (in_frame),
        .take      (take),
        .last      (last),
        .load      (load),
        .out_idx   (out_idx)
    );

    sfp_tx_path #(.W(W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .tx_word  (tx_word),
        .in_frame (in_frame),
        .out_idx  (out_idx),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    sfp_rx_path #(.W(W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .last     (last),
        .din      (din),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );

endmodule

// File: rtl/sfp_port_chk.sv
// Port-level temporal checks for sfp_port, attached by bind.
module sfp_port_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic sync_n,
    input logic pol,
    input logic edge_mode,
    input logic dout,
    input logic dout_oe,
    input logic rx_valid
);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R2

    AST_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(sclk) != $past(sclk, 2))); // R2

    AST_SAMPLE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(sclk) == !$past(pol))); // R3

    AST_LEVEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!edge_mode) && $past(sync_n)) |-> !dout_oe); // R4

    AST_VALID_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(dout_oe)); // R8

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dout_oe) && dout_oe && ($past(sclk) == $past(sclk, 2))
         && ($past(sync_n) == $past(sync_n, 2))) |-> $stable(dout)); // R10

endmodule

bind sfp_port sfp_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .sync_n    (sync_n),
    .pol       (pol),
    .edge_mode (edge_mode),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .rx_valid  (rx_valid)
);

// File: tb/sfp_port_tb_top.sv
module sfp_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sync_n = 1'b1;
    logic        din = 1'b0;
    logic        pol = 1'b0;
    logic        edge_mode = 1'b0;
    logic [15:0] tx_word = '0;
    logic        dout;
    logic        dout_oe;
    logic [15:0] rx_word;
    logic        rx_valid;

    int          total = 0;
    int          bad = 0;
    logic        v1;
    logic        v2;
    logic [15:0] w1;

    always #2 clk = ~clk;

    sfp_port dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
        .pol(pol), .edge_mode(edge_mode), .tx_word(tx_word), .dout(dout),
        .dout_oe(dout_oe), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    // One serial bit: check dout, drive din, sampling edge, shift edge.
    task automatic do_bit(input logic expb, input logic dinb, input string tag);
        chk(dout_oe === 1'b1 && dout === expb, tag, {dout_oe, dout}, {1'b1, expb});
        din  = dinb;
        sclk = ~pol;
        tick; v1 = rx_valid; w1 = rx_word;
        tick; v2 = rx_valid;
        sclk = pol;
        tick; tick;
    endtask

    // A full 16-bit frame; optionally releases sync after the first bit.
    task automatic run_word(input logic [15:0] txw, input logic [15:0] rxw, input bit rel, input string tag);
        for (int i = 0; i < 16; i++) begin
            do_bit(txw[15-i], rxw[15-i], {tag, " R1 dout bit"});
            if (i == 0 && rel) sync_n = 1'b1;
            if (i == 3) tx_word = ~txw;  // R10 mid-frame change
            if (i < 15) chk(v1 === 1'b0, {tag, " R2 early valid"}, v1, 0);
        end
        chk(v1 === 1'b1 && w1 === rxw, {tag, " R2 word"}, {v1, w1}, {1'b1, rxw});
        chk(v2 === 1'b0, {tag, " R2 strobe width"}, v2, 0);
    endtask

    task automatic set_idle(input logic p, input logic m);
        sync_n = 1'b1; pol = p; sclk = p; edge_mode = m;
        tick; tick; tick;
    endtask

    task automatic open_frame;
        sync_n = 1'b0;
        tick; tick;
    endtask

    function automatic logic [15:0] pat(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h8001;
            default: return 16'hA5C3 ^ 16'(k * 16'h1357);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R12 reset state
        tick; tick; tick; tick;
        chk(dout_oe === 0 && dout === 0 && rx_valid === 0 && rx_word === 0,
            "R12 reset", {dout_oe, dout, rx_valid, rx_word}, 0);
        rst_n = 1'b1;
        tick; tick;

        // Sweep modes, polarities and patterns (R1 R2 R3 R4 R7 R10)
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [15:0] txw;
                    logic [15:0] rxw;
                    txw = pat(k);
                    rxw = {pat(k + 3)[7:0], ~pat(k)[15:8]};
                    set_idle(p[0], m[0]);
                    chk(dout_oe === 1'b0, "R4 idle enable", dout_oe, 0);
                    tx_word = txw;
                    open_frame;
                    chk(dout_oe === 1'b1, "R4 R7 enable at start", dout_oe, 1);
                    run_word(txw, rxw, m[0], p[0] ? "R3 pol1" : "R3 pol0");
                    if (m == 1) begin
                        chk(dout_oe === 1'b0, "R7 enable after 16", dout_oe, 0);
                    end else begin
                        chk(dout_oe === 1'b1, "R4 enable while low", dout_oe, 1);
                        sync_n = 1'b1;
                        tick; tick;
                        chk(dout_oe === 1'b0, "R4 enable after release", dout_oe, 0);
                    end
                end
            end
        end

        // R8 edge mode: extra clocks ignored
        set_idle(1'b0, 1'b1);
        tx_word = 16'h1234;
        open_frame;
        run_word(16'h1234, 16'hBEEF, 1'b1, "R7 edge");
        for (int i = 0; i < 4; i++) begin
            sclk = 1'b1; tick;
            chk(rx_valid === 0 && dout_oe === 0, "R8 extra clock", {rx_valid, dout_oe}, 0);
            tick; sclk = 1'b0; tick; tick;
        end

        // R6 level mode abort, clocks while high ignored, then clean frame
        set_idle(1'b0, 1'b0);
        tx_word = 16'hC0DE;
        open_frame;
        for (int i = 0; i < 8; i++) do_bit(tx_word[15-i], 1'b1, "R6 partial");
        sync_n = 1'b1;
        tick; tick;
        chk(dout_oe === 1'b0, "R6 enable after abort", dout_oe, 0);
        for (int i = 0; i < 6; i++) begin
            din = 1'b1; sclk = 1'b1; tick;
            chk(rx_valid === 1'b0, "R6 clock while high", rx_valid, 0);
            tick; sclk = 1'b0; tick; tick;
        end
        tx_word = 16'h0F0F;
        open_frame;
        run_word(16'h0F0F, 16'h3C96, 1'b0, "R6 R9 fresh frame");
        sync_n = 1'b1; tick; tick;

        // R9 edge mode restart mid-frame
        set_idle(1'b1, 1'b1);
        tx_word = 16'h7777;
        open_frame;
        for (int i = 0; i < 5; i++) do_bit(1'(16'h7777 >> (15 - i)), 1'b0, "R9 pre");
        sync_n = 1'b1; tick; tick;
        tx_word = 16'h9A9A;
        open_frame;
        chk(dout_oe === 1'b1 && dout === 1'b1, "R9 restart bit15", {dout_oe, dout}, 2'b11);
        run_word(16'h9A9A, 16'h5511, 1'b1, "R9 restarted");

        // R5 level mode, sync held low across two groups
        set_idle(1'b0, 1'b0);
        tx_word = 16'hD00D;
        open_frame;
        run_word(16'hD00D, 16'h1248, 1'b0, "R5 group1");
        chk(dout_oe === 1'b1, "R5 enable between groups", dout_oe, 1);
        run_word(~16'hD00D, 16'h8421, 1'b0, "R5 group2");
        sync_n = 1'b1; tick; tick;

        // R11 end of frame coincides with a new sync fall (edge mode)
        set_idle(1'b0, 1'b1);
        tx_word = 16'h6B2D;
        open_frame;
        for (int i = 0; i < 15; i++) begin
            do_bit(1'(16'h6B2D >> (15 - i)), 1'(16'hF00F >> (15 - i)), "R11 first frame");
            if (i == 0) sync_n = 1'b1;
        end
        chk(dout === 1'b1 && dout_oe === 1'b1, "R11 last bit", {dout_oe, dout}, 2'b11);
        din = 1'b1; tx_word = 16'h4C4C;
        sclk = 1'b1; sync_n = 1'b0;
        tick;
        chk(rx_valid === 1'b1 && rx_word === 16'hF00F, "R11 word delivered", {rx_valid, rx_word}, {1'b1, 16'hF00F});
        tick; sclk = 1'b0; tick; tick;
        chk(dout_oe === 1'b1 && dout === 1'b0, "R11 new frame open", {dout_oe, dout}, 2'b10);
        run_word(16'h4C4C, 16'h2D2D, 1'b1, "R11 second frame");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule